// File: doc/BRIEF.md
# Token-Ring Adapter Host Glue

This block connects a byte-wide host I/O window to the system interface of a token-ring controller. Three control registers sit in the lower half of the window. The upper half is an eight-byte data window. Control bits route the data window to one of three places: the controller's register file, the first page of a small configuration ROM, or the second page of that ROM. The block also drives the controller's active-low reset and the ring-speed select pin, and holds the cable-interface select.

The controller raises an interrupt request asynchronously. The block synchronises it to the host clock and catches its rising edge in a latch. It shows the latch in a read-only status bit and passes it to a shared, level-sensitive host interrupt line while the enable bit is set. Software clears the latch by turning the enable bit off and then on again.

The controller has eight 16-bit registers and three select bits, but only two window address bits reach it. The third select bit comes from a register-page bit in control register 1. Within each register, the lowest window address bit picks the byte. The controller is modelled here as a register-file stub. The ROM contents come from parameters.

Top module: `tr_host_glue`

## Requirements
- R1: After reset every control register reads 0x00, `ctrl_rst_n` is 0, `speed_16` is 0, `cable_utp` is 0 and `host_irq` is 0. The ROM is mapped, page zero.
- R2: Map select is control register 0 (offset 0x0) bit 2, and ROM page is bit 3. With both at 0, window offsets 0x8 to 0xD read, in order: the manufacturer ID, the adapter type, the revision, then config mirror bytes 0, 1 and 2. Offsets 0xE and 0xF read 0x00.
- R3: With the ROM mapped and page bit 1, offset 0x8 reads 0x00. Offsets 0x9 to 0xE read the 48-bit station address, most significant byte first. Offset 0xF reads 0x00.
- R4: With map select 1, the window reaches controller register {CR1 bit 3, addr[2:1]}. addr[0]=0 selects the low byte and addr[0]=1 the high byte. Written bytes read back.
- R5: While `ctrl_rst_n` is 0, controller registers are cleared and writes to them are ignored. Writes to the window while the ROM is mapped change nothing.
- R6: Control register 1 (offset 0x1) bit 0 drives `ctrl_rst_n`, so writing 0x00 holds the controller in reset. Bit 2 drives `speed_16`: 1 selects 16 Mb/s and 0 selects 4 Mb/s.
- R7: Control register 7 (offset 0x7) bit 0 drives `cable_utp`: 1 selects UTP and 0 selects STP.
- R8: A rising edge on `ctrl_irq_req` sets the interrupt latch within four clock edges, whether or not interrupts are enabled. Control register 0 bit 7 shows the latch and is read-only.
- R9: `host_irq` is high exactly while the latch is set and control register 1 bit 1 is 1. It stays high until one of those changes.
- R10: Writing control register 1 with bit 1 going from 0 to 1 clears the latch. A request held high does not set it again; only a new rising edge does.
- R11: Control register 0 reads back bits 3 and 2 plus status bit 7. Control register 1 reads back bits 3:0. Control register 7 reads back bit 0. Offsets 0x2 to 0x6 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 4 | Window address: bit 3 = 0 for control registers, 1 for data window |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| ctrl_irq_req | input | 1 | Controller interrupt request, asynchronous |
| host_irq | output | 1 | Shared level-sensitive host interrupt |
| ctrl_rst_n | output | 1 | Controller reset, active low |
| speed_16 | output | 1 | Ring speed select, 1 = 16 Mb/s |
| cable_utp | output | 1 | Cable select, 1 = UTP, 0 = STP |

## Verification
The bench builds the block with its default parameters. The ROM values are distinct, non-zero and asymmetric: manufacturer 0x4D, type 0x08, revision 0x02, mirrors 0x5A/0x21/0x93, station 40:00:12:34:56:78. A swapped offset, a reversed station-address order or a dropped page bit therefore shows up as a wrong byte. The two-stage synchroniser default makes the edge-to-latch delay short, so the bench can watch a request held high across a re-arm and confirm that only a fresh edge re-sets the latch.

// File: rtl/glue_pkg.sv
package glue_pkg;
    localparam int DATA_W = 8;

    // control register offsets (host_addr[2:0] with host_addr[3] = 0)
    localparam logic [2:0] OFS_CR0 = 3'd0;
    localparam logic [2:0] OFS_CR1 = 3'd1;
    localparam logic [2:0] OFS_CR7 = 3'd7;

    // CR0: bit 3 rom page, bit 2 map select, bit 7 pending (read-only)
    typedef struct packed {
        logic rom_page;
        logic map_ctrl;
    } cr0_t;

    // CR1: bit 3 reg page, bit 2 speed, bit 1 irq enable, bit 0 run
    typedef struct packed {
        logic reg_page;
        logic speed;
        logic irq_en;
        logic run;
    } cr1_t;

    localparam int CR1_IRQ_EN_BIT = 1;
endpackage

// File: rtl/cfg_rom.sv
module cfg_rom #(
    parameter logic [7:0]  MFR_ID       = 8'h4D,
    parameter logic [7:0]  ADAPTER_TYPE = 8'h08,
    parameter logic [7:0]  REVISION     = 8'h02,
    parameter logic [23:0] CFG_MIRROR   = 24'h5A_21_93,
    parameter logic [47:0] STATION      = 48'h40_00_12_34_56_78
) (
    input  logic       page,
    input  logic [2:0] offset,
    output logic [7:0] data
);
    localparam int NBYTES = 6;

    always_comb begin
        data = 8'h00;
        if (!page) begin
            case (offset)
                3'd0: data = MFR_ID;
                3'd1: data = ADAPTER_TYPE;
                3'd2: data = REVISION;
                3'd3: data = CFG_MIRROR[23:16];
                3'd4: data = CFG_MIRROR[15:8];
                3'd5: data = CFG_MIRROR[7:0];
                default: data = 8'h00;
            endcase
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                if (offset == 3'(i + 1))
                    data = STATION[8*(NBYTES-1-i) +: 8];
            end
        end
    end
endmodule

// File: rtl/ctrl_stub.sv
module ctrl_stub #(
    parameter int SEL_W  = 3,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic              byte_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int NREG  = 1 << SEL_W;
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] regs_d [NREG];
    logic [WORD_W-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (!run)
                regs_d[i] = '0;
            else if (wr_en && sel == SEL_W'(i)) begin
                if (byte_hi) regs_d[i][WORD_W-1:BYTE_W] = wdata;
                else         regs_d[i][BYTE_W-1:0]      = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdata = byte_hi ? regs_q[sel][WORD_W-1:BYTE_W] : regs_q[sel][BYTE_W-1:0];
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    input  logic rearm,
    output logic pending,
    output logic rise
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   pend;
    } state_t;

    state_t st_d, st_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb st_d.sync = req_async;
        end else begin : g_chain
            always_comb st_d.sync = {st_q.sync[SYNC_STAGES-2:0], req_async};
        end
    endgenerate

    assign rise = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;

    always_comb begin
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        st_d.pend = rise | (st_q.pend & ~rearm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;
endmodule

// File: rtl/tr_host_glue.sv
module tr_host_glue
    import glue_pkg::*;
#(
    parameter int          ADDR_W       = 4,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [7:0]  MFR_ID       = 8'h4D,
    parameter logic [7:0]  ADAPTER_TYPE = 8'h08,
    parameter logic [7:0]  REVISION     = 8'h02,
    parameter logic [23:0] CFG_MIRROR   = 24'h5A_21_93,
    parameter logic [47:0] STATION      = 48'h40_00_12_34_56_78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ctrl_irq_req,
    output logic              host_irq,
    output logic              ctrl_rst_n,
    output logic              speed_16,
    output logic              cable_utp
);
    localparam int OFS_W = ADDR_W - 1;
    localparam int SEL_W = OFS_W;

    typedef struct packed {
        cr0_t cr0;
        cr1_t cr1;
        logic cable;
    } regs_t;

    regs_t r_d, r_q;

    logic             in_win;
    logic [OFS_W-1:0] ofs;
    logic             ctl_wr, stub_wr, rearm;
    logic             pending, irq_rise;
    logic [DATA_W-1:0] rom_data, stub_data;
    cr1_t             cr1_new;

    assign in_win  = host_addr[ADDR_W-1];
    assign ofs     = host_addr[OFS_W-1:0];
    assign ctl_wr  = host_wr && !in_win;
    assign stub_wr = host_wr && in_win && r_q.cr0.map_ctrl;
    assign cr1_new = cr1_t'(host_wdata[3:0]);
    assign rearm   = ctl_wr && (ofs == OFS_CR1) && cr1_new.irq_en && !r_q.cr1.irq_en;

    always_comb begin
        r_d = r_q;
        if (ctl_wr) begin
            case (ofs)
                OFS_CR0: r_d.cr0 = cr0_t'(host_wdata[3:2]);
                OFS_CR1: r_d.cr1 = cr1_new;
                OFS_CR7: r_d.cable = host_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    cfg_rom #(
        .MFR_ID(MFR_ID), .ADAPTER_TYPE(ADAPTER_TYPE), .REVISION(REVISION),
        .CFG_MIRROR(CFG_MIRROR), .STATION(STATION)
    ) rom_i (
        .page   (r_q.cr0.rom_page),
        .offset (ofs),
        .data   (rom_data)
    );

    ctrl_stub #(.SEL_W(SEL_W), .BYTE_W(DATA_W)) stub_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.cr1.run),
        .wr_en   (stub_wr),
        .sel     ({r_q.cr1.reg_page, ofs[OFS_W-1:1]}),
        .byte_hi (ofs[0]),
        .wdata   (host_wdata),
        .rdata   (stub_data)
    );

    irq_latch #(.SYNC_STAGES(SYNC_STAGES)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (ctrl_irq_req),
        .rearm     (rearm),
        .pending   (pending),
        .rise      (irq_rise)
    );

    always_comb begin
        host_rdata = '0;
        if (in_win)
            host_rdata = r_q.cr0.map_ctrl ? stub_data : rom_data;
        else begin
            case (ofs)
                OFS_CR0: host_rdata = {pending, 3'b000, r_q.cr0, 2'b00};
                OFS_CR1: host_rdata = {4'h0, r_q.cr1};
                OFS_CR7: host_rdata = {7'h00, r_q.cable};
                default: host_rdata = '0;
            endcase
        end
    end

    assign host_irq   = pending & r_q.cr1.irq_en;
    assign ctrl_rst_n = r_q.cr1.run;
    assign speed_16   = r_q.cr1.speed;
    assign cable_utp  = r_q.cable;
endmodule

// File: rtl/tr_host_glue_chk.sv
module tr_host_glue_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_irq,
    input logic              ctrl_rst_n,
    input logic              cable_utp,
    input logic              irq_en,
    input logic              irq_pending,
    input logic              irq_rise
);
    logic cr1_wr, cr7_wr;
    assign cr1_wr = host_wr && host_addr == ADDR_W'(1);
    assign cr7_wr = host_wr && host_addr == ADDR_W'(7);

    AST_PEND_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> $past(irq_rise)); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !cr1_wr) |=> host_irq); // R9
    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_en) && !$past(irq_rise)) |-> !irq_pending); // R10
    AST_RUN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rst_n) |-> $past(cr1_wr)); // R6
    AST_CABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cr7_wr |=> $stable(cable_utp)); // R7
endmodule

bind tr_host_glue tr_host_glue_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_irq    (host_irq),
    .ctrl_rst_n  (ctrl_rst_n),
    .cable_utp   (cable_utp),
    .irq_en      (r_q.cr1.irq_en),
    .irq_pending (pending),
    .irq_rise    (irq_rise)
);

// File: tb/tr_host_glue_tb_top.sv
module tr_host_glue_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       ctrl_irq_req = 1'b0;
    logic       host_irq, ctrl_rst_n, speed_16, cable_utp;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tr_host_glue dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctrl_irq_req(ctrl_irq_req), .host_irq(host_irq),
        .ctrl_rst_n(ctrl_rst_n), .speed_16(speed_16), .cable_utp(cable_utp)
    );

    // {write, addr, data, expected}
    localparam int NV = 36;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'h0, 8'h00, 8'h00}, // R1 cr0
        {1'b0, 4'h1, 8'h00, 8'h00}, // R1 cr1
        {1'b0, 4'h8, 8'h00, 8'h4D}, // R2
        {1'b0, 4'h9, 8'h00, 8'h08},
        {1'b0, 4'hA, 8'h00, 8'h02},
        {1'b0, 4'hB, 8'h00, 8'h5A},
        {1'b0, 4'hC, 8'h00, 8'h21},
        {1'b0, 4'hD, 8'h00, 8'h93},
        {1'b0, 4'hE, 8'h00, 8'h00},
        {1'b1, 4'h0, 8'h08, 8'h00}, // page one
        {1'b0, 4'h8, 8'h00, 8'h00}, // R3
        {1'b0, 4'h9, 8'h00, 8'h40},
        {1'b0, 4'hA, 8'h00, 8'h00},
        {1'b0, 4'hB, 8'h00, 8'h12},
        {1'b0, 4'hC, 8'h00, 8'h34},
        {1'b0, 4'hD, 8'h00, 8'h56},
        {1'b0, 4'hE, 8'h00, 8'h78},
        {1'b0, 4'hF, 8'h00, 8'h00},
        {1'b0, 4'h0, 8'h00, 8'h08}, // R11
        {1'b1, 4'h1, 8'h01, 8'h00}, // release controller
        {1'b1, 4'h0, 8'h04, 8'h00}, // map controller
        {1'b1, 4'h8, 8'hAA, 8'h00}, // R4
        {1'b1, 4'h9, 8'hBB, 8'h00},
        {1'b1, 4'hA, 8'hCC, 8'h00},
        {1'b0, 4'h8, 8'h00, 8'hAA},
        {1'b0, 4'h9, 8'h00, 8'hBB},
        {1'b0, 4'hA, 8'h00, 8'hCC},
        {1'b0, 4'hB, 8'h00, 8'h00},
        {1'b1, 4'h1, 8'h09, 8'h00}, // reg page 1
        {1'b0, 4'h8, 8'h00, 8'h00},
        {1'b1, 4'h8, 8'h11, 8'h00},
        {1'b0, 4'h8, 8'h00, 8'h11},
        {1'b1, 4'h1, 8'h01, 8'h00}, // reg page 0
        {1'b0, 4'h8, 8'h00, 8'hAA},
        {1'b0, 4'h1, 8'h00, 8'h01}, // R11
        {1'b0, 4'h3, 8'h00, 8'h00}  // R11 unused
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string req, input logic [7:0] exp);
        @(negedge clk);
        host_addr = a;
        #1 check(req, host_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 outputs at reset
        check("R1 ctrl_rst_n", {7'd0, ctrl_rst_n}, 8'h00);
        check("R1 speed_16", {7'd0, speed_16}, 8'h00);
        check("R1 cable_utp", {7'd0, cable_utp}, 8'h00);
        check("R1 host_irq", {7'd0, host_irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
            else rd(VEC[i][19:16], $sformatf("R2-4/11 vec %0d", i), VEC[i][7:0]);
        end

        // R5: controller reset clears and blocks writes
        wr(4'h1, 8'h00);
        wr(4'h8, 8'h55);
        check("R6 ctrl_rst_n low", {7'd0, ctrl_rst_n}, 8'h00);
        wr(4'h1, 8'h01);
        rd(4'h8, "R5 cleared reg", 8'h00);
        rd(4'h9, "R5 cleared reg hi", 8'h00);
        // R5: writes with ROM mapped are ignored
        wr(4'h0, 8'h00);
        wr(4'h8, 8'hFF);
        rd(4'h8, "R5 rom write ignored", 8'h4D);
        wr(4'h0, 8'h04);
        rd(4'h8, "R5 stub untouched by rom write", 8'h00);

        // R6 speed
        wr(4'h1, 8'h05);
        check("R6 speed 16", {7'd0, speed_16}, 8'h01);
        check("R6 run", {7'd0, ctrl_rst_n}, 8'h01);
        wr(4'h1, 8'h01);
        check("R6 speed 4", {7'd0, speed_16}, 8'h00);

        // R7 cable
        wr(4'h7, 8'hFF);
        check("R7 utp", {7'd0, cable_utp}, 8'h01);
        rd(4'h7, "R7 readback", 8'h01);
        wr(4'h7, 8'h00);
        check("R7 stp", {7'd0, cable_utp}, 8'h00);

        // R8 latch sets with irq disabled
        ctrl_irq_req = 1'b1;
        idle(4);
        rd(4'h0, "R8 pending set", 8'h84);
        check("R9 masked", {7'd0, host_irq}, 8'h00);
        wr(4'h0, 8'h04);
        rd(4'h0, "R8 status read-only", 8'h84);

        // R9 level output
        wr(4'h1, 8'h03);
        check("R10 rearm clears even with req high", {7'd0, host_irq}, 8'h00);
        idle(5);
        rd(4'h0, "R10 no re-set on held level", 8'h04);
        ctrl_irq_req = 1'b0;
        idle(3);
        ctrl_irq_req = 1'b1;
        idle(4);
        check("R9 irq asserted", {7'd0, host_irq}, 8'h01);
        idle(6);
        check("R9 irq held", {7'd0, host_irq}, 8'h01);
        wr(4'h1, 8'h01);
        check("R9 irq off when disabled", {7'd0, host_irq}, 8'h00);
        rd(4'h0, "R10 latch kept while disabled", 8'h84);
        wr(4'h1, 8'h03);
        rd(4'h0, "R10 latch cleared by toggle", 8'h04);
        check("R10 host_irq low", {7'd0, host_irq}, 8'h00);
        ctrl_irq_req = 1'b0;

        // R1 again: reset mid-run returns to reset state
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd(4'h1, "R1 cr1 after reset", 8'h00);
        rd(4'h8, "R1 rom mapped after reset", 8'h4D);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule